// File: doc/BRIEF.md
# Port Pin Monitor Interrupt Unit

This unit watches four already-synchronized port pins and raises one interrupt request when the first watched pin leaves a shared, programmable idle level. Once that request has been raised, more activity raises nothing new. The unit must first see every watched pin back at the idle level, which re-arms it. A typical use is to wake a processor on a keypad press so that it can scan the keys. The processor then does not have to poll the port.

Software programs the unit through a small write bus that has two 4-bit registers. The primary register holds a mask bit, the idle-level select and a 2-bit priority code. The auxiliary register holds one enable bit per pin. The priority code picks one of four request lines, at priority levels 7, 5, 3 and 1. A request line stays high until the processor acknowledges it. Any register write flushes a pending request. It also flushes a request that the write itself would have caused.

Top module: `pin_monitor_irq`

## Requirements
- R1: Bit i of the enable register (written with `wr_aux_i`=1) enables `pins_i[i]`. A pin whose bit is 0 never causes a request.
- R2: Primary register bit 2 selects the idle level: 1 means idle high, so a pin reading 0 has left idle; 0 means idle low, so a pin reading 1 has left idle.
- R3: When the monitor is armed and an enabled pin is sampled away from idle at a clock edge, a request is pending from that edge onward. It stays pending until it is acknowledged or a register write flushes it.
- R4: After a request has been raised, no new request is raised until a clock edge samples every enabled pin at idle. That edge re-arms the monitor.
- R5: Primary register bit 3 is the mask. When it is 1, all four `irq_o` lines are low.
- R6: Primary register bits 1:0 are the priority code. Code 00 drives `irq_o[0]` (level 7), 01 drives `irq_o[1]` (level 5), 10 drives `irq_o[2]` (level 3) and 11 drives `irq_o[3]` (level 1). At most one line is ever high.
- R7: A write to either register clears the pending request. It also disarms the monitor, so a departure that is present during or right after the write raises nothing until all enabled pins are back at idle.
- R8: Reset sets the primary register to 1111b (masked, idle high, code 11) and the enable register to 0000b, and all `irq_o` lines are low.
- R9: `ack_i` clears the pending request. If a departure and `ack_i` arrive in the same cycle, the new request is latched only if the monitor was armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | 4 | Synchronized pin levels |
| wr_en_i | input | 1 | Register write strobe |
| wr_aux_i | input | 1 | Register select: 0 selects the primary (priority/mask) register, 1 selects the auxiliary (enable) register |
| wr_data_i | input | 4 | Write data |
| ack_i | input | 1 | Interrupt acknowledge |
| irq_o | output | 4 | One-hot request lines for levels 7, 5, 3 and 1 |

## Verification
The main function is tried with several pin patterns:
- A single enabled pin leaving idle shows that a request is raised.
- A second enabled pin leaving while the first is still out, and the first pin returning while the second stays out, show that the monitor re-arms only after every enabled pin is back at idle.
- Activity on a disabled pin separates the enable bits from the pin levels.

The same departures are repeated with both idle levels and with all four priority codes. This tells apart the edge polarity and the decoder. Further patterns test the interactions:
- a departure arriving in the same cycle as an acknowledge, both armed and disarmed;
- a departure arriving during a register write;
- a departure while the mask is set.

// File: rtl/pmi_pkg.sv
package pmi_pkg;
  localparam int unsigned REG_W  = 4;
  localparam int unsigned NUM_LVL = 4;
  localparam int unsigned CODE_W = $clog2(NUM_LVL);

  typedef struct packed {
    logic              mask;
    logic              idle_hi;
    logic [CODE_W-1:0] code;
  } pri_cfg_t;

  localparam pri_cfg_t PRI_RST = '{mask: 1'b1, idle_hi: 1'b1, code: '1};
endpackage

// File: rtl/pmi_regs.sv
module pmi_regs
  import pmi_pkg::*;
#(
  parameter int unsigned NUM_PINS = REG_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                wr_aux_i,
  input  logic [REG_W-1:0]    wr_data_i,
  output pri_cfg_t            pri_o,
  output logic [NUM_PINS-1:0] en_o
);
  pri_cfg_t            pri_q;
  logic [NUM_PINS-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pri_q <= PRI_RST;
      en_q  <= '0;
    end else if (wr_en_i) begin
      if (wr_aux_i) en_q  <= wr_data_i[NUM_PINS-1:0];
      else          pri_q <= pri_cfg_t'(wr_data_i);
    end
  end

  assign pri_o = pri_q;
  assign en_o  = en_q;
endmodule

// File: rtl/pmi_detect.sv
module pmi_detect #(
  parameter int unsigned NUM_PINS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic [NUM_PINS-1:0] en_i,
  input  logic                idle_hi_i,
  input  logic                wr_i,
  input  logic                ack_i,
  output logic                pending_o
);
  logic [NUM_PINS-1:0] away;
  logic                any_away, fire;
  logic                armed_q, pending_q;

  // idle high: a low pin has departed
  assign away     = (pins_i ^ {NUM_PINS{idle_hi_i}}) & en_i;
  assign any_away = |away;
  assign fire     = armed_q & any_away & ~wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        armed_q <= 1'b0;
    else if (wr_i)      armed_q <= 1'b0;
    else if (!any_away) armed_q <= 1'b1;
    else if (fire)      armed_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pending_q <= 1'b0;
    else if (wr_i)  pending_q <= 1'b0;
    else if (fire)  pending_q <= 1'b1;
    else if (ack_i) pending_q <= 1'b0;
  end

  assign pending_o = pending_q;

  a_r7_wr_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !pending_q);
  a_r4_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |=> !$rose(pending_q));
  a_r1_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |=> !$rose(pending_q));
  a_r9_ack_disarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !armed_q) |=> !pending_q);
endmodule

// File: rtl/pmi_prio_dec.sv
module pmi_prio_dec
  import pmi_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               mask_i,
  input  logic [CODE_W-1:0]  code_i,
  output logic [NUM_LVL-1:0] irq_o
);
  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    assign irq_o[g] = req_i & ~mask_i & (code_i == CODE_W'(g));
  end

  a_r6_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_o));
endmodule

// File: rtl/pin_monitor_irq.sv
module pin_monitor_irq
  import pmi_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [REG_W-1:0]   pins_i,
  input  logic               wr_en_i,
  input  logic               wr_aux_i,
  input  logic [REG_W-1:0]   wr_data_i,
  input  logic               ack_i,
  output logic [NUM_LVL-1:0] irq_o
);
  pri_cfg_t         pri;
  logic [REG_W-1:0] en;
  logic             pending;

  pmi_regs #(.NUM_PINS(REG_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_aux_i, .wr_data_i,
    .pri_o(pri), .en_o(en)
  );

  pmi_detect #(.NUM_PINS(REG_W)) u_detect (
    .clk_i, .rst_ni, .pins_i, .en_i(en), .idle_hi_i(pri.idle_hi),
    .wr_i(wr_en_i), .ack_i, .pending_o(pending)
  );

  pmi_prio_dec u_dec (
    .clk_i, .rst_ni, .req_i(pending), .mask_i(pri.mask),
    .code_i(pri.code), .irq_o
  );

  a_r5_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pri.mask |-> (irq_o == '0));
  a_r8_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (irq_o == '0));
endmodule

// File: tb/sim_pin_monitor_irq.sv
module sim_pin_monitor_irq;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] pins = 4'b1111;
  logic       wr_en = 1'b0, wr_aux = 1'b0, ack = 1'b0;
  logic [3:0] wr_data = 4'b0000;
  logic [3:0] irq_o;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  pin_monitor_irq u0 (
    .clk_i(clk), .rst_ni(rst_ni), .pins_i(pins), .wr_en_i(wr_en),
    .wr_aux_i(wr_aux), .wr_data_i(wr_data), .ack_i(ack), .irq_o(irq_o)
  );

  // {req[18:15], wr, aux, data[4], pins[4], ack, exp[4]}
  localparam int NV = 37;
  localparam logic [18:0] VEC [NV] = '{
    {4'd6, 1'b1,1'b0,4'b0100, 4'b1111, 1'b0, 4'b0000},
    {4'd1, 1'b1,1'b1,4'b0011, 4'b1111, 1'b0, 4'b0000},
    {4'd4, 1'b0,1'b0,4'b0000, 4'b1111, 1'b0, 4'b0000},
    {4'd3, 1'b0,1'b0,4'b0000, 4'b1110, 1'b0, 4'b0001},
    {4'd4, 1'b0,1'b0,4'b0000, 4'b1100, 1'b0, 4'b0001},
    {4'd9, 1'b0,1'b0,4'b0000, 4'b1100, 1'b1, 4'b0000},
    {4'd4, 1'b0,1'b0,4'b0000, 4'b1101, 1'b0, 4'b0000},
    {4'd4, 1'b0,1'b0,4'b0000, 4'b1111, 1'b0, 4'b0000},
    {4'd1, 1'b0,1'b0,4'b0000, 4'b1011, 1'b0, 4'b0000},
    {4'd3, 1'b0,1'b0,4'b0000, 4'b1101, 1'b0, 4'b0001},
    {4'd9, 1'b0,1'b0,4'b0000, 4'b1111, 1'b1, 4'b0000},
    {4'd6, 1'b1,1'b0,4'b0101, 4'b1111, 1'b0, 4'b0000},
    {4'd4, 1'b0,1'b0,4'b0000, 4'b1111, 1'b0, 4'b0000},
    {4'd6, 1'b0,1'b0,4'b0000, 4'b1110, 1'b0, 4'b0010},
    {4'd9, 1'b0,1'b0,4'b0000, 4'b1111, 1'b1, 4'b0000},
    {4'd6, 1'b1,1'b0,4'b0110, 4'b1111, 1'b0, 4'b0000},
    {4'd4, 1'b0,1'b0,4'b0000, 4'b1111, 1'b0, 4'b0000},
    {4'd6, 1'b0,1'b0,4'b0000, 4'b1110, 1'b0, 4'b0100},
    {4'd9, 1'b0,1'b0,4'b0000, 4'b1101, 1'b1, 4'b0000},
    {4'd4, 1'b0,1'b0,4'b0000, 4'b1111, 1'b0, 4'b0000},
    {4'd7, 1'b1,1'b0,4'b0111, 4'b1110, 1'b0, 4'b0000},
    {4'd7, 1'b0,1'b0,4'b0000, 4'b1110, 1'b0, 4'b0000},
    {4'd4, 1'b0,1'b0,4'b0000, 4'b1111, 1'b0, 4'b0000},
    {4'd6, 1'b0,1'b0,4'b0000, 4'b1110, 1'b0, 4'b1000},
    {4'd7, 1'b1,1'b1,4'b0011, 4'b1110, 1'b0, 4'b0000},
    {4'd4, 1'b0,1'b0,4'b0000, 4'b1111, 1'b0, 4'b0000},
    {4'd2, 1'b1,1'b0,4'b0011, 4'b0000, 1'b0, 4'b0000},
    {4'd2, 1'b0,1'b0,4'b0000, 4'b0000, 1'b0, 4'b0000},
    {4'd2, 1'b0,1'b0,4'b0000, 4'b0010, 1'b0, 4'b1000},
    {4'd9, 1'b0,1'b0,4'b0000, 4'b0000, 1'b1, 4'b0000},
    {4'd5, 1'b1,1'b0,4'b1011, 4'b0000, 1'b0, 4'b0000},
    {4'd5, 1'b0,1'b0,4'b0000, 4'b0000, 1'b0, 4'b0000},
    {4'd5, 1'b0,1'b0,4'b0000, 4'b0001, 1'b0, 4'b0000},
    {4'd9, 1'b0,1'b0,4'b0000, 4'b0000, 1'b1, 4'b0000},
    {4'd2, 1'b1,1'b0,4'b0011, 4'b0000, 1'b0, 4'b0000},
    {4'd4, 1'b0,1'b0,4'b0000, 4'b0000, 1'b0, 4'b0000},
    {4'd9, 1'b0,1'b0,4'b0000, 4'b0001, 1'b1, 4'b1000}
  };

  function automatic string tag(input logic [3:0] n);
    case (n)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [3:0] exp);
    tests++;
    if (irq_o !== exp) begin
      fails++;
      $display("FAIL %s irq_o=%b expected %b", req, irq_o, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic step(input logic w, input logic a, input logic [3:0] d,
                      input logic [3:0] p, input logic k);
    wr_en = w; wr_aux = a; wr_data = d; pins = p; ack = k;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; wr_en = 1'b0; ack = 1'b0; pins = 4'b1111;
    #1 check("R8", 4'b0000);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][14], VEC[i][13], VEC[i][12:9], VEC[i][8:5], VEC[i][4]);
      check(tag(VEC[i][18:15]), VEC[i][3:0]);
    end

    // R8: reset leaves the mask set
    do_reset();
    step(1'b1, 1'b1, 4'b0001, 4'b1111, 1'b0);
    step(1'b0, 1'b0, 4'b0000, 4'b1111, 1'b0);
    step(1'b0, 1'b0, 4'b0000, 4'b1110, 1'b0);
    check("R8", 4'b0000);

    // R8 / R1: reset leaves every pin disabled
    do_reset();
    step(1'b1, 1'b0, 4'b0100, 4'b1111, 1'b0);
    step(1'b0, 1'b0, 4'b0000, 4'b1111, 1'b0);
    step(1'b0, 1'b0, 4'b0000, 4'b0000, 1'b0);
    check("R8", 4'b0000);
    step(1'b1, 1'b1, 4'b0001, 4'b1111, 1'b0);
    step(1'b0, 1'b0, 4'b0000, 4'b1111, 1'b0);
    step(1'b0, 1'b0, 4'b0000, 4'b0111, 1'b0);
    check("R1", 4'b0000);
    step(1'b0, 1'b0, 4'b0000, 4'b0110, 1'b0);
    check("R3", 4'b0001);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule